// File: doc/BRIEF.md
# Table-Driven Multi-Level Sync Waveform Sequencer

This block builds the sync-level waveform of a whole video frame from small programmable tables instead of fixed horizontal and vertical counters. A frame is a list of runs; each run repeats one line type for a programmed number of lines. Each line type names a line pattern. A pattern is a short series of timed segments, and each segment carries a duration and a 2-bit index into a table of four output levels. Tri-level pulses, broad vertical pulses and equalising lines are therefore all just table contents.

A host port writes and reads every table by direct address. While the enable input is low the sequencer waits at frame start and drives level zero. Once enabled it walks the tables at one step per pixel clock. An external frame trigger restarts the frame, with the first segment's counter loaded from a programmable preset so the output phase can be aligned to an outside timing source.

Top module: `sync_pattern_engine`

## Requirements
- R1: After reset every table and the trigger preset read as 0. While `en` is low, `sync_level` is 0.
- R2: Host access uses `host_sel` and `host_addr`. A write commits at the clock edge where `host_we` is high, and `host_rdata` shows the addressed entry combinationally. The encodings are: sel 0 = run entry, with type pointer in bits [3:0] and line count in bits [13:4]; sel 1 = line type, with pattern pointer in bits [2:0]; sel 2 = segment at address pattern*4+segment, with stored duration in bits [9:0] and level index in bits [11:10]; sel 3 = level table entry 0..3, bits [7:0]; sel 4 = trigger preset, bits [9:0].
- R3: A write to an address beyond the addressed table's size changes nothing, and reading such an address returns 0.
- R4: A segment with stored duration d lasts d+1 pixel clocks. During that time `sync_level` equals the level table entry selected by the segment's index.
- R5: Segment 0 of a pattern is always played. A later segment with stored duration 0 ends the line. A line also ends after its last segment (segment 3).
- R6: A run entry plays its line type for `count` lines and then advances to the next entry. Passing the last entry, or reaching an entry with count 0, wraps to entry 0.
- R7: `frame_trig` high at a clock edge while enabled restarts at run entry 0, line 0, segment 0, with the duration counter loaded from the trigger preset. That first segment therefore lasts preset+1 clocks.
- R8: The level table is applied to the output combinationally, so a rewritten level shows up on the next segment that selects it.
- R9: When `en` rises, the sequence starts from frame start: run entry 0, segment 0, full programmed duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable |
| frame_trig | input | 1 | External frame restart trigger |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Table select |
| host_addr | input | 5 | Entry address within the selected table |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Readback of the addressed entry |
| sync_level | output | 8 | Current sync output level |

## Verification
The checker assumes that `frame_trig` and `en` are synchronous single-bit levels. It also assumes the preset it samples is the register value before any write at the same edge, so the trigger-load property compares against the previous cycle's preset. The stimulus rewrites tables only while the sequencer is disabled, or while it is running on entries unaffected by the write, so the hold property on segment and run pointers is never broken by a mid-segment table change. Every frame the bench plays uses nonzero counts for the runs it reaches and a level table of four distinct values, so each observed level identifies its segment without doubt.

// File: rtl/sps_pkg.sv
package sps_pkg;

   typedef enum logic [2:0] {
      SEL_RUN  = 3'd0,
      SEL_TYPE = 3'd1,
      SEL_SEG  = 3'd2,
      SEL_LVL  = 3'd3,
      SEL_TRIG = 3'd4
   } host_sel_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sps_tables.sv
module sps_tables
   import sps_pkg::*;
#(
   parameter int N_RUN  = 15,
   parameter int N_TYPE = 15,
   parameter int N_PAT  = 7,
   parameter int SEGS   = 4,
   parameter int CNT_W  = 10,
   parameter int DUR_W  = 10,
   parameter int IDX_W  = 2,
   parameter int LVL_W  = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_we,
   input  logic [2:0]                host_sel,
   input  logic [ADDR_W-1:0]         host_addr,
   input  logic [DATA_W-1:0]         host_wdata,
   output logic [DATA_W-1:0]         host_rdata,
   output logic [CNT_W-1:0]          run_cnt [N_RUN],
   output logic [$clog2(N_TYPE)-1:0] run_typ [N_RUN],
   output logic [$clog2(N_PAT)-1:0]  typ_pat [N_TYPE],
   output logic [DUR_W-1:0]          seg_dur [N_PAT*SEGS],
   output logic [IDX_W-1:0]          seg_idx [N_PAT*SEGS],
   output logic [LVL_W-1:0]          lvl_tab [1<<IDX_W],
   output logic [DUR_W-1:0]          trig_preset
);
   localparam int RUN_AW  = $clog2(N_RUN);
   localparam int TYP_AW  = $clog2(N_TYPE);
   localparam int PAT_AW  = $clog2(N_PAT);
   localparam int FLAT_N  = N_PAT * SEGS;
   localparam int FLAT_AW = $clog2(FLAT_N);
   localparam int N_LVL   = 1 << IDX_W;

   host_sel_e sel;
   assign sel = host_sel_e'(host_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_RUN; i++) begin
            run_cnt[i] <= '0;
            run_typ[i] <= '0;
         end
         for (int i = 0; i < N_TYPE; i++) typ_pat[i] <= '0;
         for (int i = 0; i < FLAT_N; i++) begin
            seg_dur[i] <= '0;
            seg_idx[i] <= '0;
         end
         for (int i = 0; i < N_LVL; i++) lvl_tab[i] <= '0;
         trig_preset <= '0;
      end else if (host_we) begin
         case (sel)
            SEL_RUN: if (int'(host_addr) < N_RUN) begin
               run_typ[host_addr[RUN_AW-1:0]] <= host_wdata[TYP_AW-1:0];
               run_cnt[host_addr[RUN_AW-1:0]] <= host_wdata[TYP_AW +: CNT_W];
            end
            SEL_TYPE: if (int'(host_addr) < N_TYPE)
               typ_pat[host_addr[TYP_AW-1:0]] <= host_wdata[PAT_AW-1:0];
            SEL_SEG: if (int'(host_addr) < FLAT_N) begin
               seg_dur[host_addr[FLAT_AW-1:0]] <= host_wdata[DUR_W-1:0];
               seg_idx[host_addr[FLAT_AW-1:0]] <= host_wdata[DUR_W +: IDX_W];
            end
            SEL_LVL: if (int'(host_addr) < N_LVL)
               lvl_tab[host_addr[IDX_W-1:0]] <= host_wdata[LVL_W-1:0];
            SEL_TRIG: trig_preset <= host_wdata[DUR_W-1:0];
            default: ;
         endcase
      end
   end

   // R3: out-of-range reads return zero
   always_comb begin
      host_rdata = '0;
      case (sel)
         SEL_RUN: if (int'(host_addr) < N_RUN) begin
            host_rdata[TYP_AW-1:0]      = run_typ[host_addr[RUN_AW-1:0]];
            host_rdata[TYP_AW +: CNT_W] = run_cnt[host_addr[RUN_AW-1:0]];
         end
         SEL_TYPE: if (int'(host_addr) < N_TYPE)
            host_rdata[PAT_AW-1:0] = typ_pat[host_addr[TYP_AW-1:0]];
         SEL_SEG: if (int'(host_addr) < FLAT_N) begin
            host_rdata[DUR_W-1:0]      = seg_dur[host_addr[FLAT_AW-1:0]];
            host_rdata[DUR_W +: IDX_W] = seg_idx[host_addr[FLAT_AW-1:0]];
         end
         SEL_LVL: if (int'(host_addr) < N_LVL)
            host_rdata[LVL_W-1:0] = lvl_tab[host_addr[IDX_W-1:0]];
         SEL_TRIG: host_rdata[DUR_W-1:0] = trig_preset;
         default: ;
      endcase
   end

endmodule

// File: rtl/sps_sequencer.sv
module sps_sequencer #(
   parameter int N_RUN  = 15,
   parameter int N_TYPE = 15,
   parameter int N_PAT  = 7,
   parameter int SEGS   = 4,
   parameter int CNT_W  = 10,
   parameter int DUR_W  = 10,
   parameter int IDX_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      trig,
   input  logic [CNT_W-1:0]          run_cnt [N_RUN],
   input  logic [$clog2(N_TYPE)-1:0] run_typ [N_RUN],
   input  logic [$clog2(N_PAT)-1:0]  typ_pat [N_TYPE],
   input  logic [DUR_W-1:0]          seg_dur [N_PAT*SEGS],
   input  logic [IDX_W-1:0]          seg_idx [N_PAT*SEGS],
   input  logic [DUR_W-1:0]          trig_preset,
   output logic [$clog2(N_RUN)-1:0]  run_ptr,
   output logic [$clog2(SEGS)-1:0]   seg_ptr,
   output logic [DUR_W-1:0]          dcnt,
   output logic [IDX_W-1:0]          cur_idx
);
   localparam int RUN_AW  = $clog2(N_RUN);
   localparam int TYP_AW  = $clog2(N_TYPE);
   localparam int PAT_AW  = $clog2(N_PAT);
   localparam int SEG_AW  = $clog2(SEGS);
   localparam int FLAT_AW = $clog2(N_PAT*SEGS);

   logic [CNT_W-1:0]   line_done;
   logic [FLAT_AW-1:0] cur_flat;
   logic               last_seg, seg_more, run_done;
   logic [DUR_W-1:0]   nxt_dur, line_dur, home_dur;
   logic [RUN_AW-1:0]  adv_run, line_run;
   int                 step;

   // out-of-range type or pattern pointers fall back to entry 0
   function automatic logic [FLAT_AW-1:0] flat_of(input logic [RUN_AW-1:0] r,
                                                   input logic [SEG_AW-1:0] s);
      logic [TYP_AW-1:0] t;
      logic [PAT_AW-1:0] p;
      t = (int'(run_typ[r]) < N_TYPE) ? run_typ[r] : '0;
      p = (int'(typ_pat[t]) < N_PAT) ? typ_pat[t] : '0;
      return FLAT_AW'(int'(p) * SEGS + int'(s));
   endfunction

   always_comb begin
      cur_flat = flat_of(run_ptr, seg_ptr);
      cur_idx  = seg_idx[cur_flat];
      last_seg = (int'(seg_ptr) == SEGS - 1);
      nxt_dur  = last_seg ? '0 : seg_dur[FLAT_AW'(int'(cur_flat) + 1)];
      seg_more = !last_seg && (nxt_dur != '0);
      run_done = (run_cnt[run_ptr] == '0) ||
                 ((CNT_W+1)'(line_done) + 1'b1 >= (CNT_W+1)'(run_cnt[run_ptr]));
      step     = int'(run_ptr) + 1;
      adv_run  = '0;
      if (step < N_RUN) begin
         if (run_cnt[RUN_AW'(step)] != '0) adv_run = RUN_AW'(step);
      end
      line_run = run_done ? adv_run : run_ptr;
      line_dur = seg_dur[flat_of(line_run, '0)];
      home_dur = seg_dur[flat_of('0, '0)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_ptr   <= '0;
         seg_ptr   <= '0;
         line_done <= '0;
         dcnt      <= '0;
      end else if (!en) begin
         run_ptr   <= '0;
         seg_ptr   <= '0;
         line_done <= '0;
         dcnt      <= home_dur;
      end else if (trig) begin
         run_ptr   <= '0;
         seg_ptr   <= '0;
         line_done <= '0;
         dcnt      <= trig_preset;
      end else if (dcnt != '0) begin
         dcnt <= dcnt - 1'b1;
      end else if (seg_more) begin
         seg_ptr <= seg_ptr + 1'b1;
         dcnt    <= nxt_dur;
      end else begin
         seg_ptr <= '0;
         dcnt    <= line_dur;
         if (run_done) begin
            run_ptr   <= line_run;
            line_done <= '0;
         end else begin
            line_done <= line_done + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sync_pattern_engine.sv
module sync_pattern_engine
   import sps_pkg::*;
#(
   parameter int N_RUN   = 15,
   parameter int N_TYPE  = 15,
   parameter int N_PAT   = 7,
   parameter int SEGS    = 4,
   parameter int CNT_W   = 10,
   parameter int DUR_W   = 10,
   parameter int IDX_W   = 2,
   parameter int LVL_W   = 8,
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b0,
   localparam int ADDR_W = $clog2(max_int(max_int(N_RUN, N_TYPE),
                                          max_int(N_PAT*SEGS, 1<<IDX_W)))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              frame_trig,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [LVL_W-1:0]  sync_level
);
   localparam int RUN_AW = $clog2(N_RUN);
   localparam int TYP_AW = $clog2(N_TYPE);
   localparam int PAT_AW = $clog2(N_PAT);
   localparam int SEG_AW = $clog2(SEGS);
   localparam int FLAT_N = N_PAT * SEGS;
   localparam int N_LVL  = 1 << IDX_W;

   if (N_RUN < 2 || N_TYPE < 2 || N_PAT < 2 || SEGS < 2) begin : g_bad_depth
      $error("sync_pattern_engine: table depths must be at least 2");
   end
   if (TYP_AW + CNT_W > DATA_W || DUR_W + IDX_W > DATA_W || LVL_W > DATA_W) begin : g_bad_width
      $error("sync_pattern_engine: host data word too narrow for a table field");
   end

   logic [CNT_W-1:0]  run_cnt [N_RUN];
   logic [TYP_AW-1:0] run_typ [N_RUN];
   logic [PAT_AW-1:0] typ_pat [N_TYPE];
   logic [DUR_W-1:0]  seg_dur [FLAT_N];
   logic [IDX_W-1:0]  seg_idx [FLAT_N];
   logic [LVL_W-1:0]  lvl_tab [N_LVL];
   logic [DUR_W-1:0]  trig_preset;
   logic [RUN_AW-1:0] run_ptr;
   logic [SEG_AW-1:0] seg_ptr;
   logic [DUR_W-1:0]  dcnt;
   logic [IDX_W-1:0]  cur_idx;
   logic [LVL_W-1:0]  lvl_now;

   sps_tables #(
      .N_RUN(N_RUN), .N_TYPE(N_TYPE), .N_PAT(N_PAT), .SEGS(SEGS), .CNT_W(CNT_W),
      .DUR_W(DUR_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) tables_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .run_cnt(run_cnt), .run_typ(run_typ), .typ_pat(typ_pat),
      .seg_dur(seg_dur), .seg_idx(seg_idx), .lvl_tab(lvl_tab), .trig_preset(trig_preset)
   );

   sps_sequencer #(
      .N_RUN(N_RUN), .N_TYPE(N_TYPE), .N_PAT(N_PAT), .SEGS(SEGS),
      .CNT_W(CNT_W), .DUR_W(DUR_W), .IDX_W(IDX_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .en(en), .trig(frame_trig),
      .run_cnt(run_cnt), .run_typ(run_typ), .typ_pat(typ_pat),
      .seg_dur(seg_dur), .seg_idx(seg_idx), .trig_preset(trig_preset),
      .run_ptr(run_ptr), .seg_ptr(seg_ptr), .dcnt(dcnt), .cur_idx(cur_idx)
   );

   assign lvl_now = en ? lvl_tab[cur_idx] : '0;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_level <= '0;
         else        sync_level <= lvl_now;
      end
   end else begin : g_comb_out
      assign sync_level = lvl_now;
   end

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
   parameter int N_RUN  = 15,
   parameter int SEGS   = 4,
   parameter int RUN_AW = 4,
   parameter int SEG_AW = 2,
   parameter int DUR_W  = 10,
   parameter int LVL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              trig,
   input logic [LVL_W-1:0]  sync_level,
   input logic [RUN_AW-1:0] run_ptr,
   input logic [SEG_AW-1:0] seg_ptr,
   input logic [DUR_W-1:0]  dcnt,
   input logic [DUR_W-1:0]  trig_preset
);

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> sync_level == '0); // R1

   AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (run_ptr == '0 && seg_ptr == '0)); // R9

   AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !trig && dcnt != '0) |=> ($stable(seg_ptr) && $stable(run_ptr))); // R4

   AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && trig) |=> (run_ptr == '0 && seg_ptr == '0 && dcnt == $past(trig_preset))); // R7

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(run_ptr) < N_RUN && int'(seg_ptr) < SEGS)); // R6

endmodule

bind sync_pattern_engine sps_checker #(
   .N_RUN(N_RUN), .SEGS(SEGS), .RUN_AW(RUN_AW), .SEG_AW(SEG_AW),
   .DUR_W(DUR_W), .LVL_W(LVL_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .en(en), .trig(frame_trig), .sync_level(sync_level),
   .run_ptr(run_ptr), .seg_ptr(seg_ptr), .dcnt(dcnt), .trig_preset(trig_preset)
);

// File: tb/sync_pattern_engine_tb_top.sv
module sync_pattern_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              frame_trig = 1'b0;
   logic              host_we = 1'b0;
   logic [2:0]        host_sel = '0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic [DATA_W-1:0] host_rdata;
   logic [7:0]        sync_level;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_pattern_engine dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .frame_trig(frame_trig),
      .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .sync_level(sync_level)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic hw(input logic [2:0] s, input int a, input int d);
      cyc();
      host_we = 1'b1; host_sel = s; host_addr = ADDR_W'(a); host_wdata = DATA_W'(d);
      cyc();
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, input int a, input int e, input string req);
      cyc();
      host_sel = s; host_addr = ADDR_W'(a);
      #1;
      chk(int'(host_rdata) == e, req, int'(host_rdata), e);
   endtask

   task automatic add(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(v);
   endtask

   task automatic play(input string req);
      for (int i = 0; i < exp_q.size(); i++) begin
         @(negedge clk);
         chk(sync_level == exp_q[i], req, int'(sync_level), int'(exp_q[i]));
      end
      exp_q = {};
   endtask

   // two lines of 2x sync + 3x black, one line of 4x null + 2x level3
   task automatic add_base_frame();
      add(8'h10, 2); add(8'h40, 3);
      add(8'h10, 2); add(8'h40, 3);
      add(8'h80, 4); add(8'hC0, 2);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(sync_level == 8'h00, "R1 idle level", int'(sync_level), 0);
      rd(3'd0, 0, 0, "R1 run table cleared");
      rd(3'd4, 0, 0, "R1 trigger preset cleared");
   endtask

   task automatic t_program();
      hw(3'd3, 0, 'h10); hw(3'd3, 1, 'h40); hw(3'd3, 2, 'h80); hw(3'd3, 3, 'hC0);
      hw(3'd2, 0, 'h0001); hw(3'd2, 1, 'h0402);
      hw(3'd2, 4, 'h0803); hw(3'd2, 5, 'h0C01);
      hw(3'd1, 0, 0); hw(3'd1, 1, 1);
      hw(3'd0, 0, 'h020); hw(3'd0, 1, 'h011);
      hw(3'd4, 0, 2);
      rd(3'd0, 0, 'h020, "R2 run entry readback");
      rd(3'd2, 1, 'h0402, "R2 segment readback");
      rd(3'd3, 3, 'hC0, "R2 level readback");
      rd(3'd1, 1, 1, "R2 type readback");
      rd(3'd4, 0, 2, "R2 preset readback");
   endtask

   task automatic t_frame();
      cyc();
      en = 1'b1;
      add_base_frame();
      add_base_frame();
      play("R4 R5 R6 frame sequence");
   endtask

   task automatic t_trigger();
      cyc(); frame_trig = 1'b1;
      cyc(); frame_trig = 1'b0;
      add(8'h10, 3); add(8'h40, 3);
      add(8'h10, 2); add(8'h40, 3);
      add(8'h80, 4); add(8'hC0, 1);
      play("R7 trigger restart with preset");
   endtask

   task automatic t_restart_level();
      cyc(); en = 1'b0;
      @(negedge clk);
      chk(sync_level == 8'h00, "R1 level zero when disabled", int'(sync_level), 0);
      hw(3'd3, 1, 'h55);
      cyc(); en = 1'b1;
      add(8'h10, 2); add(8'h55, 3);
      play("R8 R9 restart with rewritten level");
      cyc(); en = 1'b0;
      hw(3'd3, 1, 'h40);
   endtask

   task automatic t_out_of_range();
      hw(3'd1, 15, 5);
      rd(3'd1, 15, 0, "R3 type write past end");
      hw(3'd3, 4, 'hEE);
      rd(3'd3, 4, 0, "R3 level write past end");
      rd(3'd3, 0, 'h10, "R3 level 0 untouched");
      rd(3'd1, 0, 0, "R3 type 0 untouched");
   endtask

   task automatic t_full_pattern();
      hw(3'd2, 8, 'h0001); hw(3'd2, 9, 'h0401);
      hw(3'd2, 10, 'h0801); hw(3'd2, 11, 'h0C01);
      hw(3'd1, 2, 2);
      hw(3'd0, 2, 'h012);
      cyc(); en = 1'b1;
      add_base_frame();
      add(8'h10, 2); add(8'h40, 2); add(8'h80, 2); add(8'hC0, 2);
      add(8'h10, 2);
      play("R5 R6 last segment and wrap");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_program();
      t_frame();
      t_trigger();
      t_restart_level();
      t_out_of_range();
      t_full_pattern();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule